// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block writes incoming Ethernet frames into memory through a ring of receive buffer descriptors. Software prepares descriptors in memory. Each descriptor is two 32-bit words. The first word holds a 16-bit flag field in bits 31:16 and a 16-bit length field in bits 15:0. The second word holds the byte address of the data buffer. Descriptors sit 8 bytes apart, starting at a programmable ring start address.

For each frame, the engine streams a byte sequence into the buffers. The sequence is an optional two-byte zero pad, then the frame bytes, then a CRC-32. The sequence is cut into buffers of a programmable maximum size. Each descriptor is written back with its length and status flags, and the engine pulses a per-buffer or a per-frame event. A receive-activate output tells whether the next descriptor is free to take a frame.

The memory port is a single port with word addresses. A read returns data in the second cycle after the request cycle. Data bytes are written one byte lane at a time. Configuration goes in through a write-only register port. The register addresses are:

| Address | Register | Bits kept | Reset value |
|---|---|---|---|
| 0 | Ring start | byte address, low 3 bits forced to zero | 0 |
| 1 | Maximum buffer size | mask 0x3FF0 | 0 |
| 2 | Receive control | soft length limit in bits 31:16 | 0x05EE0001 |
| 3 | Hard truncation limit | mask 0x3FFF | 0x07FF |
| 4 | Options | bit 0 enables the two-byte pad | 0 |
| 5 | Poll | write-only trigger | none |

Top module: `rx_bd_ring`

## Requirements
- R1: A CRC-32 is computed over the frame bytes. It uses the reflected polynomial 0xEDB88320, starts from all ones and is complemented at the end. Its four bytes are stored after the data, most significant byte first, and they count in the stored length.
- R2: When the padded frame plus CRC is longer than the hard limit (register 3), only the first hard-limit bytes are stored. The last descriptor then carries both the truncated flag (flag bit 0) and the length-error flag (flag bit 5).
- R3: When the stored length is above the soft limit (register 2, bits 31:16), the length-error flag is set and the whole frame is still stored. The reset value of register 2 is 0x05EE0001, which gives a soft limit of 1518.
- R4: Each buffer takes min(remaining, maximum buffer size) bytes. The CRC may be split between two buffers.
- R5: The write-back clears the empty flag (flag bit 15) and keeps the wrap flag (flag bit 13). Only the final buffer of a frame gets the last flag (flag bit 11) and the error flags. A non-final buffer pulses ev_rxb once, and the final buffer pulses ev_rxf once.
- R6: After a descriptor whose wrap flag is set, the pointer returns to the ring start. Otherwise it advances by 8 bytes.
- R7: rx_active is clear out of reset. After each frame, rx_active takes the empty flag of the next descriptor.
- R8: If a descriptor fetched during a frame is not empty, the rest of the frame is dropped. No descriptor gets the last flag, no ev_rxf is pulsed, and rx_active is cleared.
- R9: With option bit 0 set, two zero bytes are stored at the start of the first buffer only, and they count in the lengths and limits.
- R10: The maximum-buffer-size register keeps only the bits under mask 0x3FF0. For example, a write of 0x25 gives 32-byte buffers.
- R11: A frame arriving while rx_active is clear is accepted and discarded, with no memory write.
- R12: A write to the ring start register reloads the pointer and polls the descriptor there. A write to the poll register polls the current descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables |
| mem_rdata | input | 32 | Read data, valid two cycles after the request cycle |
| rx_active | output | 1 | Next descriptor is empty |
| ev_rxb | output | 1 | Non-final buffer closed |
| ev_rxf | output | 1 | Final buffer of a frame closed |

## Verification
The tests use the following frame patterns:
- A short frame that fits in one buffer. This shows the CRC byte order and the last-buffer flags.
- A frame sized so that its CRC falls across a 32-byte buffer boundary. This separates correct splitting from a split that moves the CRC whole into one buffer.
- A two-descriptor ring. This shows the wrap and the rx_active poll, both with the next descriptor full and after it is re-armed.
- Frames over the soft limit and over the hard limit. These tell the length-error-only case from the truncated case.
- Padded frames of one buffer and of two buffers. These show that the pad appears in the first buffer only.
- A frame that runs into an occupied descriptor, and a frame sent while inactive. These show that both the dropped tail and the discarded frame leave memory untouched.

// File: rtl/rx_bd_pkg.sv
package rx_bd_pkg;
  localparam int LEN_W = 16;

  // Bit positions inside the 16-bit descriptor flag field
  localparam int FLG_E  = 15;
  localparam int FLG_W  = 13;
  localparam int FLG_L  = 11;
  localparam int FLG_LG = 5;
  localparam int FLG_TR = 0;

  // Register addresses
  localparam logic [2:0] CFG_RING   = 3'd0;
  localparam logic [2:0] CFG_MAXBUF = 3'd1;
  localparam logic [2:0] CFG_RCTL   = 3'd2;
  localparam logic [2:0] CFG_HARD   = 3'd3;
  localparam logic [2:0] CFG_OPT    = 3'd4;
  localparam logic [2:0] CFG_POLL   = 3'd5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_POLL_A, ST_POLL_B, ST_POLL_C,
    ST_FET_A, ST_FET_B, ST_FET_C, ST_FET_D,
    ST_STORE, ST_CLOSE, ST_SKIP
  } st_t;

  typedef enum logic [1:0] {PH_PAD, PH_DATA, PH_CRC} ph_t;
endpackage

// File: rtl/rx_bd_cfg.sv
module rx_bd_cfg
  import rx_bd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [ADDR_W-1:0] ring_base,
  output logic [LEN_W-1:0]  max_buf,
  output logic [LEN_W-1:0]  soft_lim,
  output logic [LEN_W-1:0]  hard_lim,
  output logic              shift16,
  output logic              poll_pulse,
  output logic              reload_pulse
);
  localparam logic [LEN_W-1:0]  MAXBUF_MASK = LEN_W'(16'h3FF0);
  localparam logic [LEN_W-1:0]  HARD_MASK   = LEN_W'(16'h3FFF);
  localparam logic [ADDR_W-1:0] RING_MASK   = ~ADDR_W'(7);

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_base    <= '0;
      max_buf      <= '0;
      soft_lim     <= LEN_W'(16'h05EE);
      hard_lim     <= LEN_W'(16'h07FF);
      shift16      <= 1'b0;
      poll_pulse   <= 1'b0;
      reload_pulse <= 1'b0;
    end else begin
      poll_pulse   <= we && (addr == CFG_RING || addr == CFG_POLL);
      reload_pulse <= we && (addr == CFG_RING);
      if (we) begin
        case (addr)
          CFG_RING:   ring_base <= wdata[ADDR_W-1:0] & RING_MASK;
          CFG_MAXBUF: max_buf   <= wdata[LEN_W-1:0] & MAXBUF_MASK;
          CFG_RCTL:   soft_lim  <= wdata[31:16];
          CFG_HARD:   hard_lim  <= wdata[LEN_W-1:0] & HARD_MASK;
          CFG_OPT:    shift16   <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  // R10: the kept buffer size never has a low nibble
  p_maxbuf_mask_r10: assert property (@(posedge clk) disable iff (rst)
    max_buf[3:0] == 4'h0);
endmodule

// File: rtl/rx_bd_crc.sv
module rx_bd_crc #(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_out
);
  logic [31:0] state_q, state_d;

  always_comb begin
    state_d = state_q ^ {24'h0, din};
    for (int b = 0; b < 8; b++) begin
      state_d = state_d[0] ? ((state_d >> 1) ^ POLY) : (state_d >> 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  state_q <= '1;
    else if (en)     state_q <= state_d;
  end

  assign crc_out = ~state_q;
endmodule

// File: rtl/rx_bd_len.sv
module rx_bd_len
  import rx_bd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc_total,
  input  logic             inc_stored,
  input  logic [LEN_W-1:0] hard_lim,
  input  logic [LEN_W-1:0] soft_lim,
  output logic             room,
  output logic             flag_tr,
  output logic             flag_lg
);
  logic [LEN_W-1:0] total_q, stored_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      total_q  <= '0;
      stored_q <= '0;
    end else begin
      if (inc_total)  total_q  <= total_q + 1'b1;
      if (inc_stored) stored_q <= stored_q + 1'b1;
    end
  end

  assign room    = stored_q < hard_lim;
  assign flag_tr = total_q > hard_lim;
  assign flag_lg = flag_tr || (stored_q > soft_lim);

  // R2: the stored count never exceeds the count of bytes seen
  p_stored_le_total_r2: assert property (@(posedge clk) disable iff (rst)
    stored_q <= total_q);
endmodule

// File: rtl/rx_bd_ring.sv
module rx_bd_ring
  import rx_bd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  output logic              rx_active,
  output logic              ev_rxb,
  output logic              ev_rxf
);
  localparam int WA_W = ADDR_W - 2;

  logic [ADDR_W-1:0] ring_base;
  logic [LEN_W-1:0]  max_buf, soft_lim, hard_lim;
  logic              shift16, poll_pulse, reload_pulse;

  rx_bd_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ring_base(ring_base), .max_buf(max_buf), .soft_lim(soft_lim),
    .hard_lim(hard_lim), .shift16(shift16), .poll_pulse(poll_pulse),
    .reload_pulse(reload_pulse)
  );

  st_t               state;
  ph_t               phase;
  logic [1:0]        idx;
  logic [ADDR_W-1:0] ptr, buf_addr;
  logic [LEN_W-1:0]  buf_cnt;
  logic              d_wrap, d_empty, close_last;
  logic              poll_pend, reload_pend;

  logic        frame_start, cur_avail, buf_full, need_close, take;
  logic        room, flag_tr, flag_lg;
  logic [7:0]  cur_byte;
  logic [31:0] crc_val, crc_sh;
  logic [ADDR_W-1:0] byte_addr;
  logic [15:0] wb_flags;
  logic        rdata_unused;

  assign rdata_unused = ^mem_rdata;

  assign frame_start = (state == ST_IDLE) && !poll_pend && in_valid && rx_active;
  assign cur_avail   = (phase != PH_DATA) || in_valid;
  assign buf_full    = buf_cnt >= max_buf;
  assign need_close  = (state == ST_STORE) && cur_avail && room && buf_full;
  assign take        = (state == ST_STORE) && cur_avail && !(room && buf_full);
  assign in_ready    = (state == ST_SKIP) ||
                       ((state == ST_STORE) && (phase == PH_DATA) && !(room && buf_full));
  assign crc_sh      = crc_val << {idx, 3'b000};
  assign byte_addr   = buf_addr + ADDR_W'(buf_cnt);

  always_comb begin
    case (phase)
      PH_PAD:  cur_byte = 8'h00;
      PH_DATA: cur_byte = in_data;
      default: cur_byte = crc_sh[31:24];
    endcase
  end

  always_comb begin
    wb_flags = '0;
    wb_flags[FLG_W] = d_wrap;
    if (close_last) begin
      wb_flags[FLG_L]  = 1'b1;
      wb_flags[FLG_TR] = flag_tr;
      wb_flags[FLG_LG] = flag_lg;
    end
  end

  rx_bd_crc u_crc (
    .clk(clk), .rst(rst), .clr(frame_start),
    .en(take && (phase == PH_DATA)), .din(in_data), .crc_out(crc_val)
  );

  rx_bd_len u_len (
    .clk(clk), .rst(rst), .clr(frame_start),
    .inc_total(take), .inc_stored(take && room),
    .hard_lim(hard_lim), .soft_lim(soft_lim),
    .room(room), .flag_tr(flag_tr), .flag_lg(flag_lg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      phase       <= PH_DATA;
      idx         <= '0;
      ptr         <= '0;
      buf_addr    <= '0;
      buf_cnt     <= '0;
      d_wrap      <= 1'b0;
      d_empty     <= 1'b0;
      close_last  <= 1'b0;
      poll_pend   <= 1'b0;
      reload_pend <= 1'b0;
      rx_active   <= 1'b0;
      ev_rxb      <= 1'b0;
      ev_rxf      <= 1'b0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      mem_be      <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      ev_rxb  <= 1'b0;
      ev_rxf  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (poll_pend) begin
            if (reload_pend) ptr <= ring_base;
            poll_pend   <= 1'b0;
            reload_pend <= 1'b0;
            state       <= ST_POLL_A;
          end else if (in_valid) begin
            if (rx_active) begin
              phase <= shift16 ? PH_PAD : PH_DATA;
              idx   <= '0;
              state <= ST_FET_A;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_POLL_A: begin
          mem_req  <= 1'b1;
          mem_addr <= ptr[ADDR_W-1:2];
          state    <= ST_POLL_B;
        end
        ST_POLL_B: state <= ST_POLL_C;
        ST_POLL_C: begin
          rx_active <= mem_rdata[16+FLG_E];
          state     <= ST_IDLE;
        end
        ST_FET_A: begin
          mem_req  <= 1'b1;
          mem_addr <= ptr[ADDR_W-1:2];
          state    <= ST_FET_B;
        end
        ST_FET_B: begin
          mem_req  <= 1'b1;
          mem_addr <= ptr[ADDR_W-1:2] + WA_W'(1);
          state    <= ST_FET_C;
        end
        ST_FET_C: begin
          d_empty <= mem_rdata[16+FLG_E];
          d_wrap  <= mem_rdata[16+FLG_W];
          state   <= ST_FET_D;
        end
        ST_FET_D: begin
          buf_addr <= mem_rdata[ADDR_W-1:0];
          buf_cnt  <= '0;
          if (d_empty) begin
            state <= ST_STORE;
          end else begin
            rx_active <= 1'b0;
            state     <= (phase == PH_DATA) ? ST_SKIP : ST_IDLE;
          end
        end
        ST_STORE: begin
          if (need_close) begin
            close_last <= 1'b0;
            state      <= ST_CLOSE;
          end else if (take) begin
            if (room) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= byte_addr[ADDR_W-1:2];
              mem_be    <= 4'b0001 << byte_addr[1:0];
              mem_wdata <= {4{cur_byte}};
              buf_cnt   <= buf_cnt + 1'b1;
            end
            case (phase)
              PH_PAD: begin
                idx <= idx + 1'b1;
                if (idx == 2'd1) begin
                  phase <= PH_DATA;
                  idx   <= '0;
                end
              end
              PH_DATA: if (in_last) begin
                phase <= PH_CRC;
                idx   <= '0;
              end
              default: begin
                idx <= idx + 1'b1;
                if (idx == 2'd3) begin
                  close_last <= 1'b1;
                  state      <= ST_CLOSE;
                end
              end
            endcase
          end
        end
        ST_CLOSE: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_be    <= 4'hF;
          mem_addr  <= ptr[ADDR_W-1:2];
          mem_wdata <= {wb_flags, buf_cnt};
          ev_rxf    <= close_last;
          ev_rxb    <= !close_last;
          ptr       <= d_wrap ? ring_base : ptr + ADDR_W'(8);
          state     <= close_last ? ST_POLL_A : ST_FET_A;
        end
        ST_SKIP: if (in_valid && in_last) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (poll_pulse)   poll_pend   <= 1'b1;
      if (reload_pulse) reload_pend <= 1'b1;
    end
  end

  // R5: one buffer closes at a time
  p_one_event_r5: assert property (@(posedge clk) disable iff (rst)
    !(ev_rxb && ev_rxf));
  // R5: a frame event only follows a descriptor write-back
  p_rxf_after_close_r5: assert property (@(posedge clk) disable iff (rst)
    ev_rxf |-> (mem_req && mem_we && mem_be == 4'hF));
  // R4: a buffer is never filled past its size
  p_buf_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STORE) |-> (buf_cnt <= max_buf));
  // R4: data stores touch one byte lane
  p_byte_lane_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1));
  // R11: discarding input never writes memory
  p_skip_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !mem_we);
endmodule

// File: tb/rx_bd_ring_tb_top.sv
module rx_bd_ring_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RING = 'h100;
  localparam int BUF0 = 'h400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, mem_req, mem_we, rx_active, ev_rxb, ev_rxf;
  logic [13:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0] mem_be;

  logic [31:0] mem [0:1023];
  logic tb_we = 1'b0;
  logic [9:0] tb_wa = '0;
  logic [31:0] tb_wd = '0;

  int n_chk = 0, n_fail = 0, n_rxb = 0, n_rxf = 0;
  bit done = 1'b0;
  logic [7:0] strm [0:511];
  int strm_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_bd_ring #(.ADDR_W(16)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .rx_active(rx_active),
    .ev_rxb(ev_rxb), .ev_rxf(ev_rxf)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_wa] <= tb_wd;
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[9:0]];
      end
    end
    if (ev_rxb) n_rxb <= n_rxb + 1;
    if (ev_rxf) n_rxf <= n_rxf + 1;
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input int word, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_wa = 10'(word); tb_wd = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [31:0] desc0(input int i);
    return mem[RING/4 + 2*i];
  endfunction

  function automatic logic [7:0] get_byte(input int a);
    return mem[a/4][8*(a%4) +: 8];
  endfunction

  // Build descriptors: E set where emask has a one, W on wrap_i; buffers hold 0xA5
  task automatic init_ring(input int n, input logic [7:0] emask, input int wrap_i);
    for (int i = 0; i < n; i++) begin
      poke(RING/4 + 2*i, {emask[i], 1'b0, (i == wrap_i), 13'h0, 16'h0});
      poke(RING/4 + 2*i + 1, 32'(BUF0 + i*'h100));
      for (int w = 0; w < 64; w++) poke((BUF0 + i*'h100)/4 + w, 32'hA5A5A5A5);
    end
    cfg_write(3'd0, 32'(RING));
  endtask

  task automatic send_frame(input int len, input int seed, input bit pad);
    logic [31:0] c;
    logic [7:0] d;
    c = 32'hFFFFFFFF;
    strm_len = 0;
    if (pad) begin strm[0] = 8'h00; strm[1] = 8'h00; strm_len = 2; end
    for (int i = 0; i < len; i++) begin
      d = 8'(seed + 7*i + (i >> 3));
      strm[strm_len] = d; strm_len++;
      c = c ^ {24'h0, d};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) begin strm[strm_len] = c[31-8*k -: 8]; strm_len++; end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = strm[i + (pad ? 2 : 0)];
      in_last  = (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (25) @(negedge clk);
  endtask

  task automatic check_bytes(input string req, input int bufaddr, input int soff, input int n);
    for (int k = 0; k < n; k++)
      check(req, $sformatf("byte %0d", soff + k), 32'(get_byte(bufaddr + k)), 32'(strm[soff + k]));
  endtask

  task automatic t_reset;
    check("R7", "rx_active after reset", 32'(rx_active), 0);
    check("R7", "in_ready after reset", 32'(in_ready), 0);
    check("R7", "mem_req after reset", 32'(mem_req), 0);
  endtask

  task automatic t_basic;
    int f0;
    cfg_write(3'd1, 32'h40);
    init_ring(4, 8'h0F, 3);
    check("R12", "active after ring load", 32'(rx_active), 1);
    f0 = n_rxf;
    send_frame(20, 3, 1'b0);
    check("R5", "desc0 word0", desc0(0), {16'h0800, 16'd24});
    check_bytes("R1", BUF0, 0, 24);
    check("R5", "frame events", 32'(n_rxf - f0), 1);
    check("R7", "active after frame", 32'(rx_active), 1);
  endtask

  task automatic t_split;
    int b0, f0;
    cfg_write(3'd1, 32'h25);
    init_ring(4, 8'h0F, 3);
    b0 = n_rxb; f0 = n_rxf;
    send_frame(30, 11, 1'b0);
    check("R10", "desc0 word0 (32-byte buffer)", desc0(0), {16'h0000, 16'd32});
    check("R4", "desc1 word0", desc0(1), {16'h0800, 16'd2});
    check_bytes("R4", BUF0, 0, 32);
    check_bytes("R4", BUF0 + 'h100, 32, 2);
    check("R5", "buffer events", 32'(n_rxb - b0), 1);
    check("R5", "frame events", 32'(n_rxf - f0), 1);
  endtask

  task automatic t_wrap;
    cfg_write(3'd1, 32'h40);
    init_ring(2, 8'h03, 1);
    send_frame(10, 20, 1'b0);
    send_frame(10, 40, 1'b0);
    check("R6", "desc1 keeps wrap", desc0(1), {16'h2800, 16'd14});
    check("R7", "active with next desc full", 32'(rx_active), 0);
    poke(RING/4, {16'h8000, 16'h0});
    cfg_write(3'd5, 32'h0);
    check("R12", "active after poll", 32'(rx_active), 1);
    send_frame(12, 60, 1'b0);
    check("R6", "ring start reused", desc0(0), {16'h0800, 16'd16});
    check_bytes("R6", BUF0, 0, 16);
  endtask

  task automatic t_soft;
    init_ring(4, 8'h0F, 3);
    cfg_write(3'd2, 32'h00280001);
    send_frame(50, 5, 1'b0);
    check("R3", "soft limit flags", desc0(0), {16'h0820, 16'd54});
    check_bytes("R3", BUF0, 0, 54);
    cfg_write(3'd2, 32'h05EE0001);
  endtask

  task automatic t_hard;
    init_ring(4, 8'h0F, 3);
    cfg_write(3'd3, 32'd30);
    send_frame(40, 9, 1'b0);
    check("R2", "truncated flags", desc0(0), {16'h0821, 16'd30});
    check_bytes("R2", BUF0, 0, 30);
    check("R2", "byte past limit", 32'(get_byte(BUF0 + 30)), 32'hA5);
    cfg_write(3'd3, 32'h7FF);
  endtask

  task automatic t_pad;
    cfg_write(3'd4, 32'h1);
    init_ring(4, 8'h0F, 3);
    send_frame(10, 77, 1'b1);
    check("R9", "padded length", desc0(0), {16'h0800, 16'd16});
    check_bytes("R9", BUF0, 0, 16);
    cfg_write(3'd1, 32'h20);
    init_ring(4, 8'h0F, 3);
    send_frame(40, 88, 1'b1);
    check("R9", "padded desc0", desc0(0), {16'h0000, 16'd32});
    check("R9", "padded desc1", desc0(1), {16'h0800, 16'd14});
    check_bytes("R9", BUF0 + 'h100, 32, 14);
    cfg_write(3'd4, 32'h0);
  endtask

  task automatic t_drop_and_idle;
    int b0, f0;
    cfg_write(3'd1, 32'h20);
    init_ring(4, 8'h01, 3);
    b0 = n_rxb; f0 = n_rxf;
    send_frame(60, 33, 1'b0);
    check("R8", "first desc no L", desc0(0), {16'h0000, 16'd32});
    check("R8", "full desc untouched", desc0(1), 32'h0);
    check("R8", "buffer events", 32'(n_rxb - b0), 1);
    check("R8", "no frame event", 32'(n_rxf - f0), 0);
    check("R8", "active cleared", 32'(rx_active), 0);
    send_frame(20, 44, 1'b0);
    check("R11", "desc0 unchanged", desc0(0), {16'h0000, 16'd32});
    check("R11", "desc1 unchanged", desc0(1), 32'h0);
    check("R11", "buffer1 untouched", 32'(get_byte(BUF0 + 'h100)), 32'hA5);
    check("R11", "no frame event", 32'(n_rxf - f0), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_split();
    t_wrap();
    t_soft();
    t_hard();
    t_pad();
    t_drop_and_idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule